// File: doc/BRIEF.md
# Reset and Initialization Pulse Controller

This block drives the active-low reset line of a board. The line is bidirectional and open-drain. The block also tells the register file when to restore defaults. Four things can start a reset:

- **Power-on:** clears everything and pulls the line low.
- **Software reset:** pulls the line low but keeps register contents.
- **External reset:** another device pulls the line low. The block stretches that low into a full pulse and restores defaults in the general registers.
- **Initialization command:** restores the same registers but does not touch the line.

A second timer produces a low pulse on a chassis-intrusion line. This pulse clears an external latch and can be requested from either of two control bits.

Pulse timing counts a slow tick of about 1 ms. The tick count `TICKS` defaults to 25, so the pulse lasts between 24 and 25 ms. The request inputs are the current values of self-clearing control bits. The block returns one-cycle acknowledge strobes that the register file uses to clear those bits. All requests act on the rising edge of their level, so a bit that is still set does not restart a pulse.

Top module: `rstpulse_ctl`

## Requirements
- R1: While `por_n` is low, `pin_pd` is 1, `chs_pd` is 0 and `por_clr` is 1. `por_clr` drops at the first clock edge after release. `pin_pd` stays high until `TICKS` ticks have been counted after release.
- R2: A reset-line pulse that starts at a clock edge keeps `pin_pd` at 1 until the edge that samples the `TICKS`-th `ms_tick` after the start, and drops at that edge. A tick sampled at the start edge itself is not counted.
- R3: A rising `sw_req` while `sw_en` is 1 starts a reset-line pulse. At the same edge `clr_swbit` pulses for one cycle. `reg_clr` stays 0.
- R4: While `sw_en` is 0, `sw_req` is ignored: `pin_pd` and `clr_swbit` stay 0.
- R5: A low `pin_in` while the block is not driving the line starts a reset-line pulse and raises `reg_clr` for exactly one cycle.
- R6: The block's own pulse never counts as an external reset. After its own pulse ends, with no external pull, `pin_pd` and `reg_clr` stay 0.
- R7: A rising `init_req` raises `reg_clr` and `clr_initbit` for one cycle and leaves `pin_pd` unchanged.
- R8: A rising `chs_cfg_req` or `chs_clr_req` drives `chs_pd` to 1 for `TICKS` ticks, with the same counting as R2. `clr_chsbits` is 1 for exactly the cycle in which `chs_pd` has just dropped.
- R9: A new request that arrives while a pulse is active reloads that pulse's count to the full `TICKS`.
- R10: The chassis pulse and the reset-line pulse are independent. A request for one never raises the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| ms_tick | input | 1 | One-cycle millisecond tick |
| pin_in | input | 1 | Sampled level of the reset line |
| sw_req | input | 1 | Software-reset control bit |
| sw_en | input | 1 | Reset-output enable bit |
| init_req | input | 1 | Initialization control bit |
| chs_cfg_req | input | 1 | Chassis-clear bit in the configuration register |
| chs_clr_req | input | 1 | Chassis-clear bit in the dedicated clear register |
| pin_pd | output | 1 | Pull-down enable for the reset line |
| chs_pd | output | 1 | Pull-down enable for the chassis line |
| reg_clr | output | 1 | One-cycle restore-defaults strobe for general registers |
| clr_swbit | output | 1 | Clears the software-reset bit |
| clr_initbit | output | 1 | Clears the initialization bit |
| clr_chsbits | output | 1 | Clears both chassis-clear bits |
| por_clr | output | 1 | Full power-on clear |

## Verification
The hardest case to reach is the moment the block releases its own pull-down. At that edge the pin level and the drive change together, and a false external-reset detection would appear only as a stray `reg_clr` or a second pulse. The bench models the line as a wired-AND of `pin_pd` and a bench-controlled external pull. It then watches several cycles after every self-generated pulse. Pulse lengths are swept over several tick periods, and requests are reissued part-way through a pulse so that the reload path is exercised.

// File: rtl/rstpulse_ctl.sv
module rstpulse_ctl #(
  parameter int unsigned TICKS = 25
) (
  input  logic clk,
  input  logic por_n,
  input  logic ms_tick,
  input  logic pin_in,
  input  logic sw_req,
  input  logic sw_en,
  input  logic init_req,
  input  logic chs_cfg_req,
  input  logic chs_clr_req,
  output logic pin_pd,
  output logic chs_pd,
  output logic reg_clr,
  output logic clr_swbit,
  output logic clr_initbit,
  output logic clr_chsbits,
  output logic por_clr
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(TICKS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] rst_cnt, chs_cnt;
  logic sw_q, init_q, chs_q, drove_q, por_q;

  wire sw_lvl     = sw_req & sw_en;
  wire chs_lvl    = chs_cfg_req | chs_clr_req;
  wire start_sw   = sw_lvl & ~sw_q;
  wire start_init = init_req & ~init_q;
  wire start_chs  = chs_lvl & ~chs_q;
  // a low line counts as external only if we neither drive it now nor did last cycle
  wire ext_det    = ~pin_in & ~pin_pd & ~drove_q;
  wire start_rst  = start_sw | ext_det;

  assign pin_pd  = rst_cnt != '0;
  assign chs_pd  = chs_cnt != '0;
  assign por_clr = por_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_cnt     <= FULL;
      chs_cnt     <= '0;
      sw_q        <= 1'b0;
      init_q      <= 1'b0;
      chs_q       <= 1'b0;
      drove_q     <= 1'b1;
      por_q       <= 1'b1;
      reg_clr     <= 1'b0;
      clr_swbit   <= 1'b0;
      clr_initbit <= 1'b0;
      clr_chsbits <= 1'b0;
    end else begin
      sw_q    <= sw_lvl;
      init_q  <= init_req;
      chs_q   <= chs_lvl;
      drove_q <= pin_pd;
      por_q   <= 1'b0;

      if (start_rst)             rst_cnt <= FULL;
      else if (ms_tick && pin_pd) rst_cnt <= rst_cnt - ONE;

      if (start_chs)              chs_cnt <= FULL;
      else if (ms_tick && chs_pd) chs_cnt <= chs_cnt - ONE;

      reg_clr     <= ext_det | start_init;
      clr_swbit   <= start_sw;
      clr_initbit <= start_init;
      clr_chsbits <= ~start_chs & ms_tick & (chs_cnt == ONE);
    end
  end

  // R9
  rst_reload_chk: assert property (@(posedge clk) disable iff (!por_n)
    start_rst |=> pin_pd && rst_cnt == FULL);

  // R8
  chs_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    start_chs |=> chs_pd && chs_cnt == FULL);

  // R2
  rst_end_on_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pin_pd) |-> $past(ms_tick));

  // R8
  chs_ack_at_end_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(chs_pd) |-> clr_chsbits);

  // R3
  sw_ack_active_chk: assert property (@(posedge clk) disable iff (!por_n)
    clr_swbit |-> pin_pd);

  // R7
  init_no_pin_chk: assert property (@(posedge clk) disable iff (!por_n)
    (start_init && !start_rst && !pin_pd) |=> !pin_pd);

  // R6
  no_self_trigger_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(pin_pd) && pin_in) |=> !reg_clr && !pin_pd);
endmodule

// File: tb/sim_rstpulse_ctl.sv
module sim_rstpulse_ctl;
  localparam int T = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_n = 1'b0, ms_tick = 1'b0, sw_req = 1'b0, sw_en = 1'b0, init_req = 1'b0;
  logic chs_cfg_req = 1'b0, chs_clr_req = 1'b0, ext_low = 1'b0;
  logic pin_pd, chs_pd, reg_clr, clr_swbit, clr_initbit, clr_chsbits, por_clr;
  wire pin_in = ~(pin_pd | ext_low);

  int vec = 0, bad = 0;

  rstpulse_ctl #(.TICKS(T)) u0 (
    .clk(clk), .por_n(por_n), .ms_tick(ms_tick), .pin_in(pin_in),
    .sw_req(sw_req), .sw_en(sw_en), .init_req(init_req),
    .chs_cfg_req(chs_cfg_req), .chs_clr_req(chs_clr_req),
    .pin_pd(pin_pd), .chs_pd(chs_pd), .reg_clr(reg_clr), .clr_swbit(clr_swbit),
    .clr_initbit(clr_initbit), .clr_chsbits(clr_chsbits), .por_clr(por_clr));

  task automatic chk(input string r, input logic act, input logic exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic run_pulse(input string r, input bit on_chs, input int per);
    int t = 0;
    for (int k = 0; t < T; k++) begin
      ms_tick = ((k % per) == per - 1);
      step();
      if (ms_tick) t++;
      if (on_chs) begin
        chk(r, chs_pd, t < T);
        chk(r, clr_chsbits, t == T);
        chk("R10", pin_pd, 1'b0);
      end else begin
        chk(r, pin_pd, t < T);
        chk("R10", chs_pd, 1'b0);
      end
    end
    ms_tick = 1'b0;
  endtask

  task automatic quiet_after(input string r);
    for (int k = 0; k < 6; k++) begin
      ms_tick = k[0];
      step();
      chk(r, pin_pd, 1'b0);
      chk(r, reg_clr, 1'b0);
    end
    ms_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 power-on state
    repeat (3) step();
    chk("R1", pin_pd, 1'b1);
    chk("R1", chs_pd, 1'b0);
    chk("R1", por_clr, 1'b1);
    chk("R1", reg_clr, 1'b0);
    por_n = 1'b1;
    step();
    chk("R1", por_clr, 1'b0);
    chk("R1", pin_pd, 1'b1);
    run_pulse("R1", 1'b0, 2);
    quiet_after("R6");

    // R3 / R2 software reset swept over tick periods
    sw_en = 1'b1;
    for (int per = 1; per <= 4; per++) begin
      sw_req = 1'b1;
      step();
      chk("R3", pin_pd, 1'b1);
      chk("R3", clr_swbit, 1'b1);
      chk("R3", reg_clr, 1'b0);
      sw_req = 1'b0;
      step();
      chk("R3", clr_swbit, 1'b0);
      run_pulse("R2", 1'b0, per);
      quiet_after("R6");
    end

    // R4 disabled software reset
    sw_en = 1'b0;
    sw_req = 1'b1;
    for (int k = 0; k < 8; k++) begin
      ms_tick = k[0];
      step();
      chk("R4", pin_pd, 1'b0);
      chk("R4", clr_swbit, 1'b0);
    end
    ms_tick = 1'b0;
    sw_req = 1'b0;
    step();
    sw_en = 1'b1;

    // R5 external reset
    for (int per = 1; per <= 3; per++) begin
      ext_low = 1'b1;
      step();
      chk("R5", pin_pd, 1'b1);
      chk("R5", reg_clr, 1'b1);
      ext_low = 1'b0;
      step();
      chk("R5", reg_clr, 1'b0);
      run_pulse("R5", 1'b0, per);
      quiet_after("R6");
    end

    // R7 initialization
    init_req = 1'b1;
    step();
    chk("R7", reg_clr, 1'b1);
    chk("R7", clr_initbit, 1'b1);
    chk("R7", pin_pd, 1'b0);
    init_req = 1'b0;
    step();
    chk("R7", reg_clr, 1'b0);
    chk("R7", clr_initbit, 1'b0);
    chk("R7", pin_pd, 1'b0);

    // R8 chassis pulses from either bit
    for (int per = 1; per <= 4; per++) begin
      if (per[0]) chs_cfg_req = 1'b1; else chs_clr_req = 1'b1;
      step();
      chk("R8", chs_pd, 1'b1);
      chk("R8", clr_chsbits, 1'b0);
      chk("R10", pin_pd, 1'b0);
      chs_cfg_req = 1'b0;
      chs_clr_req = 1'b0;
      run_pulse("R8", 1'b1, per);
      step();
      chk("R8", clr_chsbits, 1'b0);
      chk("R8", chs_pd, 1'b0);
    end

    // R9 restart during active reset pulse
    sw_req = 1'b1;
    step();
    sw_req = 1'b0;
    ms_tick = 1'b1;
    repeat (T - 1) step();
    chk("R9", pin_pd, 1'b1);
    ms_tick = 1'b0;
    sw_req = 1'b1;
    step();
    sw_req = 1'b0;
    run_pulse("R9", 1'b0, 1);
    quiet_after("R6");

    // R9 restart during active chassis pulse
    chs_cfg_req = 1'b1;
    step();
    chs_cfg_req = 1'b0;
    ms_tick = 1'b1;
    repeat (T - 1) step();
    chk("R9", chs_pd, 1'b1);
    ms_tick = 1'b0;
    chs_clr_req = 1'b1;
    step();
    chs_clr_req = 1'b0;
    run_pulse("R9", 1'b1, 2);

    finish_run();
  end
endmodule